// File: doc/BRIEF.md
# Floating-Point Rename Buffer File

This block is the register-renaming stage that sits in front of a 32-entry, 64-bit architectural floating-point register file. A pool of six rename buffers holds results that have been produced but not yet committed. Each dispatched instruction claims one buffer for its destination. At the same time the block reports, for each of two source registers, whether the operand lives in the architectural file, in a buffer still waiting for its result, or in a buffer that already holds its result. For the last two cases it also gives the buffer tag, and it returns the data whenever data exists.

Execution units write their results into buffers by tag. The completion logic retires instructions strictly in dispatch order. Retiring the oldest buffer copies its value into the architectural register and returns the buffer to the pool. A flush input discards all speculative state in a single cycle and leaves the architectural file untouched. A read port on the architectural file exposes committed state.

Top module: `fprn_rename_file`

## Requirements
- R1: After reset, `disp_ready` is 1, `disp_tag` is 0, every source reports kind 0 (architectural), and every architectural register reads 0.
- R2: Buffers are handed out in order 0,1,2,3,4,5,0,… and `disp_tag` shows the tag the next accepted dispatch will receive.
- R3: With six buffers in use, `disp_ready` is 0 and a dispatch request is ignored: no buffer is taken and `disp_tag` does not move.
- R4: Source kind encoding is 0 = architectural (data is the register value), 1 = pending buffer (tag valid), 2 = ready buffer (tag and data valid). When a register is renamed more than once, the youngest buffer is reported.
- R5: The source lookup uses the mapping from before the current cycle, so an instruction that reads its own destination sees the previous producer.
- R6: A writeback marks a live buffer ready and stores its data. A writeback to a buffer that is not in use has no effect.
- R7: A retire request commits the oldest buffer only if it holds a result. `ret_done` pulses in that cycle, the value appears in the architectural file from the next cycle, and the buffer is freed. Otherwise the request is ignored and `ret_done` stays 0.
- R8: Retire clears a register's mapping only if that mapping still names the retired buffer; a younger renaming survives.
- R9: A dispatch and a retire may occur in the same cycle. If both target the same register, the new mapping wins.
- R10: Flush frees all buffers, returns every source to kind 0, makes `disp_tag` 0 and `disp_ready` 1, and keeps the architectural contents. A retire requested in the flush cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all buffers and mappings |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | 5 | Destination register of dispatched instruction |
| disp_src_a | input | 5 | First source register |
| disp_src_b | input | 5 | Second source register |
| disp_ready | output | 1 | A buffer is free |
| disp_tag | output | 3 | Tag given to the next accepted dispatch |
| src_a_kind | output | 2 | Location kind of first source |
| src_a_tag | output | 3 | Buffer tag of first source |
| src_a_data | output | 64 | Data of first source |
| src_b_kind | output | 2 | Location kind of second source |
| src_b_tag | output | 3 | Buffer tag of second source |
| src_b_data | output | 64 | Data of second source |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | 3 | Buffer receiving the result |
| wb_data | input | 64 | Result value |
| ret_valid | input | 1 | Retire request for the oldest buffer |
| ret_done | output | 1 | Retire accepted this cycle |
| arch_rd_addr | input | 5 | Architectural read address |
| arch_rd_data | output | 64 | Architectural read data |

## Verification
Dispatch, writeback and retire can all hit the same register or buffer in one cycle. The cases that matter are a dispatch renaming a register whose older buffer is retiring, and a writeback arriving while a retire is requested on a buffer that is not yet ready. Random traffic confined to a few registers, with frequent retires and occasional flushes, provokes these overlaps. Directed cycles then force the exact collisions. Every cycle, each source location, the allocation tag, the stall flag, the retire pulse and the architectural contents are compared with a bench-side model built from the requirements.

// File: rtl/fprn_pkg.sv
package fprn_pkg;
    parameter int unsigned FP_W   = 64;
    parameter int unsigned ARCH_N = 32;
    parameter int unsigned RB_N   = 6;

    localparam int unsigned AREG_W = $clog2(ARCH_N);
    localparam int unsigned TAG_W  = $clog2(RB_N);
    localparam int unsigned CNT_W  = $clog2(RB_N + 1);

    typedef logic [FP_W-1:0]   fp_word_t;
    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [TAG_W-1:0]  rtag_t;

    typedef enum logic [1:0] {
        SRC_ARCH  = 2'd0,
        SRC_PEND  = 2'd1,
        SRC_READY = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic     valid;
        logic     done;
        areg_t    dst;
        fp_word_t data;
    } rb_entry_t;

    typedef struct packed {
        logic  valid;
        rtag_t tag;
    } map_entry_t;

    typedef struct packed {
        src_kind_e kind;
        rtag_t     tag;
        fp_word_t  data;
    } src_info_t;

    function automatic rtag_t tag_inc(rtag_t t);
        return (t == rtag_t'(RB_N - 1)) ? '0 : rtag_t'(t + 1'b1);
    endfunction

    function automatic src_info_t resolve_src(map_entry_t m, rb_entry_t e, fp_word_t arch_val);
        src_info_t r;
        if (!m.valid) begin
            r.kind = SRC_ARCH;
            r.tag  = '0;
            r.data = arch_val;
        end else begin
            r.kind = e.done ? SRC_READY : SRC_PEND;
            r.tag  = m.tag;
            r.data = e.done ? e.data : '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/fprn_arch_file.sv
module fprn_arch_file
    import fprn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  areg_t    waddr,
    input  fp_word_t wdata,
    input  areg_t    ra_a,
    input  areg_t    ra_b,
    input  areg_t    ra_c,
    output fp_word_t rd_a,
    output fp_word_t rd_b,
    output fp_word_t rd_c
);
    fp_word_t regs_q [ARCH_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_N; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];
    assign rd_c = regs_q[ra_c];

    // R7: a commit lands in the architectural register on the next cycle
    assert_arch_commit_R7: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/fprn_map_table.sv
module fprn_map_table
    import fprn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       set_en,
    input  areg_t      set_idx,
    input  rtag_t      set_tag,
    input  logic       clr_en,
    input  areg_t      clr_idx,
    input  rtag_t      clr_tag,
    input  areg_t      rd_a_idx,
    input  areg_t      rd_b_idx,
    output map_entry_t rd_a,
    output map_entry_t rd_b
);
    map_entry_t map_q [ARCH_N];
    logic       any_valid;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ARCH_N; i++) map_q[i] <= '0;
        end else begin
            if (clr_en && map_q[clr_idx].valid && map_q[clr_idx].tag == clr_tag)
                map_q[clr_idx].valid <= 1'b0;
            if (set_en)
                map_q[set_idx] <= '{valid: 1'b1, tag: set_tag};
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < ARCH_N; i++) any_valid = any_valid | map_q[i].valid;
    end

    assign rd_a = map_q[rd_a_idx];
    assign rd_b = map_q[rd_b_idx];

    // R8: a mapping naming a younger buffer survives a retire
    assert_keep_younger_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !flush && !(set_en && set_idx == clr_idx)
         && map_q[clr_idx].valid && map_q[clr_idx].tag != clr_tag)
        |=> map_q[$past(clr_idx)].valid);

    // R9: a new renaming wins over a same-cycle clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_en && !flush)
        |=> map_q[$past(set_idx)].valid && map_q[$past(set_idx)].tag == $past(set_tag));

    // R10: flush empties the mapping
    assert_map_flush_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !any_valid);
endmodule

// File: rtl/fprn_buf_pool.sv
module fprn_buf_pool
    import fprn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      alloc_en,
    input  areg_t     alloc_dst,
    input  logic      wb_en,
    input  rtag_t     wb_tag,
    input  fp_word_t  wb_data,
    input  logic      ret_req,
    input  rtag_t     rd_a_tag,
    input  rtag_t     rd_b_tag,
    output logic      full,
    output rtag_t     alloc_tag,
    output logic      ret_fire,
    output rtag_t     ret_tag,
    output areg_t     ret_dst,
    output fp_word_t  ret_data,
    output rb_entry_t ent_a,
    output rb_entry_t ent_b
);
    rb_entry_t        ents_q [RB_N];
    rtag_t            head_q;
    rtag_t            tail_q;
    logic [CNT_W-1:0] count_q;

    assign full      = (count_q == CNT_W'(RB_N));
    assign alloc_tag = tail_q;
    assign ret_fire  = ret_req && !flush && ents_q[head_q].valid && ents_q[head_q].done;
    assign ret_tag   = head_q;
    assign ret_dst   = ents_q[head_q].dst;
    assign ret_data  = ents_q[head_q].data;
    assign ent_a     = ents_q[rd_a_tag];
    assign ent_b     = ents_q[rd_b_tag];

    for (genvar i = 0; i < RB_N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ents_q[i] <= '0;
            end else begin
                if (wb_en && wb_tag == rtag_t'(i) && ents_q[i].valid) begin
                    ents_q[i].done <= 1'b1;
                    ents_q[i].data <= wb_data;
                end
                if (ret_fire && head_q == rtag_t'(i))
                    ents_q[i].valid <= 1'b0;
                if (alloc_en && tail_q == rtag_t'(i)) begin
                    ents_q[i].valid <= 1'b1;
                    ents_q[i].done  <= 1'b0;
                    ents_q[i].dst   <= alloc_dst;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (ret_fire) head_q <= tag_inc(head_q);
            if (alloc_en) tail_q <= tag_inc(tail_q);
            count_q <= count_q + CNT_W'(alloc_en) - CNT_W'(ret_fire);
        end
    end

    // R3: occupancy never exceeds the pool
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(RB_N));

    // R3: no buffer is granted while the pool is full
    assert_no_alloc_full_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full);

    // R2: a lone allocation grows occupancy by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !ret_fire && !flush) |=> count_q == $past(count_q) + 1'b1);

    // R10: flush empties the pool
    assert_pool_flush_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> count_q == '0 && head_q == '0 && tail_q == '0);
endmodule

// File: rtl/fprn_rename_file.sv
module fprn_rename_file
    import fprn_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        disp_valid,
    input  logic [4:0]  disp_dst,
    input  logic [4:0]  disp_src_a,
    input  logic [4:0]  disp_src_b,
    output logic        disp_ready,
    output logic [2:0]  disp_tag,
    output logic [1:0]  src_a_kind,
    output logic [2:0]  src_a_tag,
    output logic [63:0] src_a_data,
    output logic [1:0]  src_b_kind,
    output logic [2:0]  src_b_tag,
    output logic [63:0] src_b_data,
    input  logic        wb_valid,
    input  logic [2:0]  wb_tag,
    input  logic [63:0] wb_data,
    input  logic        ret_valid,
    output logic        ret_done,
    input  logic [4:0]  arch_rd_addr,
    output logic [63:0] arch_rd_data
);
    logic       full;
    logic       alloc_en;
    rtag_t      alloc_tag;
    logic       ret_fire;
    rtag_t      ret_tag;
    areg_t      ret_dst;
    fp_word_t   ret_data;
    map_entry_t map_a, map_b;
    rb_entry_t  ent_a, ent_b;
    fp_word_t   arch_a, arch_b;
    src_info_t  info_a, info_b;

    assign alloc_en = disp_valid && !full && !flush;

    fprn_buf_pool u_pool (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .alloc_en  (alloc_en),
        .alloc_dst (disp_dst),
        .wb_en     (wb_valid),
        .wb_tag    (wb_tag),
        .wb_data   (wb_data),
        .ret_req   (ret_valid),
        .rd_a_tag  (map_a.tag),
        .rd_b_tag  (map_b.tag),
        .full      (full),
        .alloc_tag (alloc_tag),
        .ret_fire  (ret_fire),
        .ret_tag   (ret_tag),
        .ret_dst   (ret_dst),
        .ret_data  (ret_data),
        .ent_a     (ent_a),
        .ent_b     (ent_b)
    );

    fprn_map_table u_map (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .set_en   (alloc_en),
        .set_idx  (disp_dst),
        .set_tag  (alloc_tag),
        .clr_en   (ret_fire),
        .clr_idx  (ret_dst),
        .clr_tag  (ret_tag),
        .rd_a_idx (disp_src_a),
        .rd_b_idx (disp_src_b),
        .rd_a     (map_a),
        .rd_b     (map_b)
    );

    fprn_arch_file u_arch (
        .clk   (clk),
        .rst   (rst),
        .we    (ret_fire),
        .waddr (ret_dst),
        .wdata (ret_data),
        .ra_a  (disp_src_a),
        .ra_b  (disp_src_b),
        .ra_c  (arch_rd_addr),
        .rd_a  (arch_a),
        .rd_b  (arch_b),
        .rd_c  (arch_rd_data)
    );

    assign info_a = resolve_src(map_a, ent_a, arch_a);
    assign info_b = resolve_src(map_b, ent_b, arch_b);

    assign disp_ready = !full;
    assign disp_tag   = alloc_tag;
    assign src_a_kind = info_a.kind;
    assign src_a_tag  = info_a.tag;
    assign src_a_data = info_a.data;
    assign src_b_kind = info_b.kind;
    assign src_b_tag  = info_b.tag;
    assign src_b_data = info_b.data;
    assign ret_done   = ret_fire;

    // R7: an accepted retire frees a buffer, so a stall clears next cycle
    assert_retire_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (ret_fire && !alloc_en) |=> disp_ready);

    // R4: a mapped source never reports the architectural kind
    assert_mapped_kind_R4: assert property (@(posedge clk) disable iff (rst)
        map_a.valid |-> src_a_kind != SRC_ARCH);
endmodule

// File: tb/fprn_rename_file_tb.sv
module fprn_rename_file_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic [4:0]  disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic [1:0]  src_a_kind, src_b_kind;
    logic [2:0]  src_a_tag, src_b_tag;
    logic [63:0] src_a_data, src_b_data;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [63:0] wb_data = '0;
    logic        ret_valid = 1'b0;
    logic        ret_done;
    logic [4:0]  arch_rd_addr = '0;
    logic [63:0] arch_rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // bench model
    logic [63:0] m_arch [32];
    bit          m_mv [32];
    int          m_mt [32];
    bit          rb_v [6];
    bit          rb_d [6];
    int          rb_dst [6];
    logic [63:0] rb_data [6];
    int          m_head, m_tail, m_cnt;

    always #4 clk = ~clk;

    fprn_rename_file dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .src_a_kind(src_a_kind), .src_a_tag(src_a_tag), .src_a_data(src_a_data),
        .src_b_kind(src_b_kind), .src_b_tag(src_b_tag), .src_b_data(src_b_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_valid(ret_valid), .ret_done(ret_done),
        .arch_rd_addr(arch_rd_addr), .arch_rd_data(arch_rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) begin m_mv[i] = 0; m_mt[i] = 0; end
        for (int i = 0; i < 6; i++) begin rb_v[i] = 0; rb_d[i] = 0; end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endfunction

    function automatic int nxt(int t);
        return (t == 5) ? 0 : t + 1;
    endfunction

    function automatic void exp_src(input int r, output int k, output int t, output logic [63:0] d);
        if (!m_mv[r]) begin k = 0; t = 0; d = m_arch[r]; end
        else begin
            t = m_mt[r];
            k = rb_d[t] ? 2 : 1;
            d = rb_d[t] ? rb_data[t] : 64'd0;
        end
    endfunction

    task automatic model_check();
        int k, t;
        logic [63:0] d;
        bit exp_ret;
        chk(disp_ready == (m_cnt < 6), "R3 ready", 64'(disp_ready), 64'(m_cnt < 6));
        chk(disp_tag == 3'(m_tail), "R2 tag", 64'(disp_tag), 64'(m_tail));
        exp_src(int'(disp_src_a), k, t, d);
        chk(src_a_kind == 2'(k), "R4 a kind", 64'(src_a_kind), 64'(k));
        if (k != 0) chk(src_a_tag == 3'(t), "R4 a tag", 64'(src_a_tag), 64'(t));
        if (k != 1) chk(src_a_data == d, "R4 a data", src_a_data, d);
        exp_src(int'(disp_src_b), k, t, d);
        chk(src_b_kind == 2'(k), "R4 b kind", 64'(src_b_kind), 64'(k));
        if (k != 0) chk(src_b_tag == 3'(t), "R4 b tag", 64'(src_b_tag), 64'(t));
        if (k != 1) chk(src_b_data == d, "R4 b data", src_b_data, d);
        exp_ret = ret_valid && !flush && rb_v[m_head] && rb_d[m_head];
        chk(ret_done == exp_ret, "R7 ret_done", 64'(ret_done), 64'(exp_ret));
        chk(arch_rd_data == m_arch[arch_rd_addr], "R7 arch", arch_rd_data, m_arch[arch_rd_addr]);
    endtask

    function automatic void model_update();
        bit rf, al;
        int hd, dst;
        logic [63:0] rdat;
        if (flush) begin
            model_reset();
            return;
        end
        rf = ret_valid && rb_v[m_head] && rb_d[m_head];
        al = disp_valid && (m_cnt < 6);
        hd = m_head; dst = rb_dst[hd]; rdat = rb_data[hd];
        if (wb_valid && wb_tag < 6 && rb_v[wb_tag]) begin
            rb_d[wb_tag] = 1; rb_data[wb_tag] = wb_data;
        end
        if (rf) begin
            m_arch[dst] = rdat;
            if (m_mv[dst] && m_mt[dst] == hd) m_mv[dst] = 0;
            rb_v[hd] = 0;
            m_head = nxt(m_head);
            m_cnt--;
        end
        if (al) begin
            m_mv[disp_dst] = 1; m_mt[disp_dst] = m_tail;
            rb_v[m_tail] = 1; rb_d[m_tail] = 0; rb_dst[m_tail] = int'(disp_dst);
            m_tail = nxt(m_tail);
            m_cnt++;
        end
    endfunction

    task automatic idle();
        flush = 0; disp_valid = 0; wb_valid = 0; ret_valid = 0;
    endtask

    task automatic settle();
        #2;
        model_check();
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic disp(input int dst);
        disp_valid = 1; disp_dst = 5'(dst);
    endtask

    task automatic wb(input int tag, input logic [63:0] d);
        wb_valid = 1; wb_tag = 3'(tag); wb_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_arch[i] = '0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        disp_src_a = 5'd9; disp_src_b = 5'd30; arch_rd_addr = 5'd17;
        #2;
        chk(disp_ready == 1'b1, "R1 ready", 64'(disp_ready), 64'd1);
        chk(disp_tag == 3'd0, "R1 tag", 64'(disp_tag), 64'd0);
        chk(src_a_kind == 2'd0 && src_b_kind == 2'd0, "R1 kind", 64'({src_a_kind, src_b_kind}), 64'd0);
        chk(arch_rd_data == 64'd0, "R1 arch", arch_rd_data, 64'd0);
        @(negedge clk);

        // R5: reading own destination sees prior state
        disp(3); disp_src_a = 5'd3; settle();
        chk(src_a_kind == 2'd0, "R5 own dst", 64'(src_a_kind), 64'd0);
        tick();
        // R4 pending; R6 writeback to free tag 5 ignored
        disp_src_a = 5'd3; wb(5, 64'hDEAD); settle();
        chk(src_a_kind == 2'd1 && src_a_tag == 3'd0, "R4 pending", 64'({src_a_kind, src_a_tag}), 64'h8);
        tick();
        disp(5); wb(0, 64'hA1); settle(); tick();
        disp(5); disp_src_a = 5'd3; settle();
        chk(src_a_kind == 2'd2 && src_a_data == 64'hA1, "R6 ready data", src_a_data, 64'hA1);
        tick();
        wb(1, 64'hB2); ret_valid = 1; settle();
        chk(ret_done == 1'b1, "R7 retire", 64'(ret_done), 64'd1);
        tick();
        wb(2, 64'hC3); ret_valid = 1; arch_rd_addr = 5'd3; settle();
        chk(arch_rd_data == 64'hA1, "R7 commit", arch_rd_data, 64'hA1);
        tick();
        // R8: younger buffer survives; R9 same-cycle dispatch and retire of f5
        disp_src_a = 5'd5; arch_rd_addr = 5'd5; disp(5); ret_valid = 1; settle();
        chk(src_a_kind == 2'd2 && src_a_tag == 3'd2 && src_a_data == 64'hC3, "R8 younger", src_a_data, 64'hC3);
        chk(arch_rd_data == 64'hB2, "R8 arch", arch_rd_data, 64'hB2);
        tick();
        disp_src_a = 5'd5; ret_valid = 1; settle();
        chk(src_a_kind == 2'd1 && src_a_tag == 3'd3, "R9 new map", 64'({src_a_kind, src_a_tag}), 64'hB);
        chk(ret_done == 1'b0, "R7 unready ignored", 64'(ret_done), 64'd0);
        chk(disp_ready == 1'b1, "R9 count", 64'(disp_ready), 64'd1);
        tick();
        // R3: fill the pool
        for (int i = 0; i < 5; i++) begin disp(10 + i); settle(); tick(); end
        disp(20); settle();
        chk(disp_ready == 1'b0, "R3 full", 64'(disp_ready), 64'd0);
        tick();
        disp_src_a = 5'd20; settle();
        chk(src_a_kind == 2'd0 && disp_tag == 3'd3, "R3 ignored", 64'({src_a_kind, disp_tag}), 64'd3);
        tick();
        // R10: flush with a retire request
        wb(3, 64'hE4); settle(); tick();
        flush = 1; ret_valid = 1; settle(); tick();
        disp_src_a = 5'd5; arch_rd_addr = 5'd5; settle();
        chk(disp_ready == 1'b1 && disp_tag == 3'd0, "R10 pool", 64'({disp_ready, disp_tag}), 64'h8);
        chk(src_a_kind == 2'd0 && src_a_data == 64'hC3, "R10 arch kept", src_a_data, 64'hC3);
        tick();

        // random traffic on a narrow register range
        for (int n = 0; n < 4000; n++) begin
            int lim;
            lim = ($urandom_range(0, 3) == 0) ? 31 : 7;
            disp_valid = ($urandom_range(0, 1) == 1);
            disp_dst = 5'($urandom_range(0, lim));
            disp_src_a = 5'($urandom_range(0, lim));
            disp_src_b = 5'($urandom_range(0, lim));
            wb_valid = ($urandom_range(0, 9) < 6);
            wb_tag = 3'($urandom_range(0, 7));
            wb_data = {$urandom, $urandom};
            ret_valid = ($urandom_range(0, 1) == 1);
            flush = ($urandom_range(0, 199) == 0);
            arch_rd_addr = 5'($urandom_range(0, lim));
            settle();
            tick();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule